// File: doc/BRIEF.md
# Linear CORDIC Multiply-Divide Engine

A fixed-point engine that multiplies or divides using only shifts and adds. It works in the linear coordinate system. In rotation mode it drives the angle word z towards zero, and the y word collects y plus x times z. In vectoring mode it drives y towards zero, and z collects z plus y divided by x. The x word passes through unchanged.

The micro-rotations are split evenly across a configurable number of register stages. The group sizes are rounded up, so the last groups may be shorter or empty. An optional output register can follow the last group. The build-time mode parameter selects one of three variants:

- rotation only;
- vectoring only;
- unified, where a per-operation input bit picks the mode.

Operands enter through a valid/ready stream and results leave through a valid/ready stream. The clock enable freezes every register.

Back-pressure rules:

- An operand is taken on a rising edge where `in_valid` and `in_ready` are both high.
- A result leaves on a rising edge where `out_valid`, `out_ready` and `ce` are all high.
- While `out_valid` is high and the result is not taken, the pipeline stalls as a whole and the output holds.

Top module: `lin_cordic`

## Requirements
- R1: `x_out` equals the `x_in` of the same operation.
- R2: Words are two's complement, and 1.0 is 2^(W-2). Micro-rotation i runs for i = 0 to ITERS-1 and uses a direction flag. In rotation the flag is up when z >= 0. In vectoring the flag is up when y < 0. When the flag is up, y += x>>>i and z -= 2^(W-2-i). Otherwise y -= x>>>i and z += 2^(W-2-i). `y_out` and `z_out` match this recurrence bit for bit.
- R3: In rotation, `y_out` is within ITERS+4 LSB of y_in + floor(x_in*z_in / 2^(W-2)) when |z_in| < 2.0 and the result fits.
- R4: In vectoring, with x_in >= 0.5 and |y_in/x_in| < 2, `z_out` is within 2*ITERS+8 LSB of z_in + y_in*2^(W-2)/x_in.
- R5: In unified mode, `vec` = 1 selects vectoring and `vec` = 0 selects rotation for each operation, and operations of different modes may follow back to back.
- R6: With `ce` and `out_ready` held high, a result becomes valid after exactly STAGES+OUT_REG rising edges, counting the edge that takes the operand.
- R7: While `ce` is low, `in_ready` is low, no result is taken, and `out_valid` and the outputs hold.
- R8: While `out_valid` is high and `out_ready` is low, the outputs hold, `in_ready` is low, and results leave in acceptance order without loss.
- R9: `in_ready` is high exactly when `ce` is high and either `out_valid` is low or `out_ready` is high.
- R10: After reset, `out_valid` is low and `in_ready` follows `ce`.
- R11: A cycle without `in_valid` adds no result. The number of results delivered equals the number of operands taken, and no more than STAGES+OUT_REG are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable for every register |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be taken |
| vec | input | 1 | Unified mode: 1 = vectoring, 0 = rotation |
| x_in | input | W | Operand x, signed |
| y_in | input | W | Operand y, signed |
| z_in | input | W | Operand z, signed, 1.0 = 2^(W-2) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result can be taken |
| x_out | output | W | Result x (pass-through) |
| y_out | output | W | Result y |
| z_out | output | W | Result z |

## Verification
The bench builds the block with W = 16, ITERS = 14, STAGES = 4, the unified mode and the output register on. Fourteen iterations over four stages give groups of 4, 4, 4 and 2, so the uneven final group is exercised. The unified mode lets one run mix rotation and vectoring operations back to back. The five-stage latency leaves room for a full pipeline to stall under random enable and back-pressure patterns.

// File: rtl/lin_cordic_pkg.sv
package lin_cordic_pkg;

  typedef enum logic [1:0] {
    LC_ROTATE  = 2'd0,
    LC_VECTOR  = 2'd1,
    LC_UNIFIED = 2'd2
  } lc_mode_e;

  // Number of micro-rotations placed in register stage g.
  function automatic int group_len(int iters, int stages, int g);
    int per;
    int rem;
    per = (iters + stages - 1) / stages;
    rem = iters - g * per;
    if (rem < 0) rem = 0;
    return (rem < per) ? rem : per;
  endfunction

endpackage

// File: rtl/lin_step.sv
module lin_step #(
  parameter int W     = 16,
  parameter int SHIFT = 0
) (
  input  logic                vec_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  input  logic signed [W-1:0] z_i,
  output logic signed [W-1:0] y_o,
  output logic signed [W-1:0] z_o
);
  localparam int CEXP = W - 2 - SHIFT;
  localparam int CSH  = (CEXP >= 0) ? CEXP : 0;
  localparam logic signed [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  localparam logic signed [W-1:0] ZC  = (CEXP >= 0) ? (ONE << CSH) : '0;

  logic signed [W-1:0] xs;
  logic                up;

  assign xs = x_i >>> SHIFT;
  assign up = vec_i ? y_i[W-1] : ~z_i[W-1];

  always_comb begin
    if (up) begin
      y_o = y_i + xs;
      z_o = z_i - ZC;
    end else begin
      y_o = y_i - xs;
      z_o = z_i + ZC;
    end
  end
endmodule

// File: rtl/lin_stage.sv
module lin_stage #(
  parameter int W     = 16,
  parameter int FIRST = 0,
  parameter int COUNT = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                v_i,
  input  logic                vec_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  input  logic signed [W-1:0] z_i,
  output logic                v_o,
  output logic                vec_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o,
  output logic signed [W-1:0] z_o
);
  logic                v_q, vec_q;
  logic signed [W-1:0] x_q, y_q, z_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      vec_q <= 1'b0;
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
    end else if (adv) begin
      v_q   <= v_i;
      vec_q <= vec_i;
      x_q   <= x_i;
      y_q   <= y_i;
      z_q   <= z_i;
    end
  end

  logic signed [W-1:0] yc [0:COUNT];
  logic signed [W-1:0] zc [0:COUNT];

  assign yc[0] = y_q;
  assign zc[0] = z_q;

  for (genvar k = 0; k < COUNT; k++) begin : g_step
    lin_step #(.W(W), .SHIFT(FIRST + k)) u_step (
      .vec_i (vec_q),
      .x_i   (x_q),
      .y_i   (yc[k]),
      .z_i   (zc[k]),
      .y_o   (yc[k+1]),
      .z_o   (zc[k+1])
    );
  end

  assign v_o   = v_q;
  assign vec_o = vec_q;
  assign x_o   = x_q;
  assign y_o   = yc[COUNT];
  assign z_o   = zc[COUNT];
endmodule

// File: rtl/lin_cordic.sv
module lin_cordic
  import lin_cordic_pkg::*;
#(
  parameter int       W       = 16,
  parameter int       ITERS   = 14,
  parameter int       STAGES  = 4,
  parameter lc_mode_e MODE    = LC_UNIFIED,
  parameter bit       OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                vec,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic signed [W-1:0] z_in,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] x_out,
  output logic signed [W-1:0] y_out,
  output logic signed [W-1:0] z_out
);
  localparam int PER = (ITERS + STAGES - 1) / STAGES;

  if (ITERS > W - 1 || ITERS < 1 || STAGES < 1) begin : g_bad_cfg
    $error("lin_cordic: need 1 <= ITERS <= W-1 and STAGES >= 1");
  end

  logic adv;
  logic eff_vec;

  // Whole-pipeline stall: move only when enabled and the output slot frees.
  assign adv      = ce && (!out_valid || out_ready);
  assign in_ready = adv;

  if (MODE == LC_ROTATE) begin : g_rot
    assign eff_vec = 1'b0;
  end else if (MODE == LC_VECTOR) begin : g_vec
    assign eff_vec = 1'b1;
  end else begin : g_uni
    assign eff_vec = vec;
  end

  logic                sv   [0:STAGES];
  logic                svec [0:STAGES];
  logic signed [W-1:0] sx   [0:STAGES];
  logic signed [W-1:0] sy   [0:STAGES];
  logic signed [W-1:0] sz   [0:STAGES];

  assign sv[0]   = in_valid;
  assign svec[0] = eff_vec;
  assign sx[0]   = x_in;
  assign sy[0]   = y_in;
  assign sz[0]   = z_in;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    localparam int FIRST = g * PER;
    localparam int CNT   = group_len(ITERS, STAGES, g);
    lin_stage #(.W(W), .FIRST(FIRST), .COUNT(CNT)) u_stg (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .v_i   (sv[g]),
      .vec_i (svec[g]),
      .x_i   (sx[g]),
      .y_i   (sy[g]),
      .z_i   (sz[g]),
      .v_o   (sv[g+1]),
      .vec_o (svec[g+1]),
      .x_o   (sx[g+1]),
      .y_o   (sy[g+1]),
      .z_o   (sz[g+1])
    );
  end

  if (OUT_REG) begin : g_oreg
    logic                ov_q;
    logic signed [W-1:0] ox_q, oy_q, oz_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ov_q <= 1'b0;
        ox_q <= '0;
        oy_q <= '0;
        oz_q <= '0;
      end else if (adv) begin
        ov_q <= sv[STAGES];
        ox_q <= sx[STAGES];
        oy_q <= sy[STAGES];
        oz_q <= sz[STAGES];
      end
    end
    assign out_valid = ov_q;
    assign x_out     = ox_q;
    assign y_out     = oy_q;
    assign z_out     = oz_q;
  end else begin : g_ocomb
    assign out_valid = sv[STAGES];
    assign x_out     = sx[STAGES];
    assign y_out     = sy[STAGES];
    assign z_out     = sz[STAGES];
  end

  logic unused_vec;
  assign unused_vec = svec[STAGES];
endmodule

// File: rtl/lin_cordic_chk.sv
module lin_cordic_chk #(
  parameter int W       = 16,
  parameter int STAGES  = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ce,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic signed [W-1:0] x_out,
  input logic signed [W-1:0] y_out,
  input logic signed [W-1:0] z_out
);
  localparam int DEPTH = STAGES + (OUT_REG ? 1 : 0);

  logic [15:0] occ;
  logic        take_in, take_out;

  assign take_in  = in_valid && in_ready;
  assign take_out = out_valid && out_ready && ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + 16'(take_in) - 16'(take_out);
  end

  assert_hold_under_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(x_out) && $stable(y_out) && $stable(z_out)));

  assert_freeze_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(out_valid) && $stable(y_out) && $stable(z_out)));

  assert_ready_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> !in_ready);

  assert_occupancy_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 16'(DEPTH));

  assert_no_phantom_output_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (occ != 16'd0));
endmodule

bind lin_cordic lin_cordic_chk #(.W(W), .STAGES(STAGES), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce        (ce),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .x_out     (x_out),
  .y_out     (y_out),
  .z_out     (z_out)
);

// File: tb/sim_lin_cordic.sv
`timescale 1ns/1ps
module sim_lin_cordic;
  import lin_cordic_pkg::*;

  localparam int W   = 16;
  localparam int IT  = 14;
  localparam int ST  = 4;
  localparam bit OR  = 1'b1;
  localparam int LAT = ST + (OR ? 1 : 0);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, in_valid = 1'b0, vec = 1'b0, out_ready = 1'b0;
  logic signed [W-1:0] x_in = '0, y_in = '0, z_in = '0;
  logic in_ready, out_valid;
  logic signed [W-1:0] x_out, y_out, z_out;

  lin_cordic #(.W(W), .ITERS(IT), .STAGES(ST), .MODE(LC_UNIFIED), .OUT_REG(OR)) u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .in_valid(in_valid), .in_ready(in_ready),
    .vec(vec), .x_in(x_in), .y_in(y_in), .z_in(z_in),
    .out_valid(out_valid), .out_ready(out_ready),
    .x_out(x_out), .y_out(y_out), .z_out(z_out)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int n_in = 0;
  int n_out = 0;
  bit fc_random = 1'b0;
  bit finished = 1'b0;
  string cur_tag = "R3";

  typedef struct {
    logic                v;
    logic signed [W-1:0] x, y, z;
    string               tag;
  } item_t;
  item_t sb[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Recurrence of R2, evaluated on W-bit words.
  function automatic void model(input logic v, input logic signed [W-1:0] x,
                                input logic signed [W-1:0] y0, input logic signed [W-1:0] z0,
                                output logic signed [W-1:0] ye, output logic signed [W-1:0] ze);
    logic signed [W-1:0] yy, zz, c;
    logic up;
    yy = y0; zz = z0;
    for (int i = 0; i < IT; i++) begin
      c = (W - 2 - i >= 0) ? W'(1 << (W - 2 - i)) : '0;
      up = v ? yy[W-1] : !zz[W-1];
      if (up) begin yy = yy + (x >>> i); zz = zz - c; end
      else    begin yy = yy - (x >>> i); zz = zz + c; end
    end
    ye = yy; ze = zz;
  endfunction

  // Monitor: compares every result that leaves at the coming edge.
  always begin
    @(negedge clk);
    #1.5;
    if (rst_n && out_valid && out_ready && ce) begin
      n_out++;
      if (sb.size() == 0) begin
        check(1'b0, "R11", "result with no operand", 1, 0);
      end else begin
        item_t it;
        logic signed [W-1:0] ye, ze;
        longint ideal, diff;
        it = sb.pop_front();
        model(it.v, it.x, it.y, it.z, ye, ze);
        check(x_out == it.x, "R1", "x_out", x_out, it.x);
        check(y_out == ye, "R2", "y_out", y_out, ye);
        check(z_out == ze, "R2", "z_out", z_out, ze);
        if (!it.v) begin
          ideal = longint'(it.y) + ((longint'(it.x) * longint'(it.z)) >>> (W - 2));
          diff = longint'(y_out) - ideal;
          if (diff < 0) diff = -diff;
          check(diff <= IT + 4, it.tag, "rotation y vs ideal", y_out, ideal);
        end else begin
          ideal = longint'(it.z) + (longint'(it.y) * (longint'(1) << (W - 2))) / longint'(it.x);
          diff = longint'(z_out) - ideal;
          if (diff < 0) diff = -diff;
          check(diff <= 2 * IT + 8, it.tag, "vectoring z vs ideal", z_out, ideal);
        end
      end
    end
  end

  // Random enable / back-pressure when requested.
  always @(negedge clk) begin
    if (fc_random) begin
      ce        = ($urandom_range(0, 9) != 0);
      out_ready = ($urandom_range(0, 3) != 0);
    end
  end

  // Driver: presents one operand and pushes it to the scoreboard when taken.
  task automatic send(input logic v, input int x, input int y, input int z);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; vec = v;
    x_in = W'(x); y_in = W'(y); z_in = W'(z);
    forever begin
      #1.5;
      if (in_ready) begin
        it.v = v; it.x = W'(x); it.y = W'(y); it.z = W'(z); it.tag = cur_tag;
        sb.push_back(it);
        n_in++;
        @(posedge clk);
        #0.5;
        in_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rand_op(input logic v);
    int x, y, z;
    if (!v) begin
      x = int'($urandom_range(0, 16384)) - 8192;
      y = int'($urandom_range(0, 16384)) - 8192;
      z = int'($urandom_range(0, 62000)) - 31000;
    end else begin
      x = int'($urandom_range(8192, 16384));
      y = int'($urandom_range(0, 2 * 14000)) - 14000;
      y = (y * x) / 8192 / 2;
      z = int'($urandom_range(0, 6000)) - 3000;
    end
    send(v, x, y, z);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    ce = 1'b1;
    out_ready = 1'b0;
    #1;
    // R10 reset state
    check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    ce = 1'b0; #0.5;
    check(in_ready == 1'b0, "R9", "in_ready with ce low", in_ready, 0);
    ce = 1'b1;
    out_ready = 1'b1;

    // R6 latency
    begin
      int n;
      cur_tag = "R3";
      send(1'b0, 8192, 0, 8192);
      n = 1;
      while (!out_valid && n < 40) begin
        @(posedge clk); #0.5; n++;
      end
      check(n == LAT, "R6", "latency in edges", n, LAT);
    end
    cycles(4);

    // R3 directed rotation
    cur_tag = "R3";
    send(1'b0, 8192, 0, 8192);
    send(1'b0, -6000, 1000, -16000);
    send(1'b0, 16384, -2000, 28000);
    send(1'b0, 12000, 3000, 0);
    // R4 directed vectoring
    cur_tag = "R4";
    send(1'b1, 16384, 8192, 0);
    send(1'b1, 8192, -12000, 1000);
    send(1'b1, 12000, 0, 0);
    send(1'b1, 9000, 15000, -2000);
    // R5 mixed back to back
    cur_tag = "R5";
    send(1'b1, 10000, 5000, 0);
    send(1'b0, 10000, 5000, 8000);
    send(1'b1, 15000, -20000, 500);
    send(1'b0, -7000, 0, -24000);
    cycles(LAT + 4);
    check(sb.size() == 0, "R5", "scoreboard drained", sb.size(), 0);

    // R8 back-pressure: three operands fill while output blocked
    out_ready = 1'b0;
    cur_tag = "R3";
    send(1'b0, 4000, 100, 4000);
    send(1'b1, 12000, 6000, 0);
    send(1'b0, -3000, -100, 12000);
    cycles(LAT + 6);
    #1;
    check(out_valid == 1'b1, "R8", "out_valid while blocked", out_valid, 1);
    check(in_ready == 1'b0, "R8", "in_ready while blocked", in_ready, 0);
    begin
      logic signed [W-1:0] hy, hz;
      hy = y_out; hz = z_out;
      cycles(5);
      #1;
      check(y_out == hy && z_out == hz, "R8", "output held", y_out, hy);
      check(in_ready == 1'b0, "R8", "in_ready still low", in_ready, 0);
      // R7: enable low with ready high takes nothing
      @(negedge clk);
      ce = 1'b0; out_ready = 1'b1;
      cycles(5);
      #1;
      check(out_valid == 1'b1 && y_out == hy, "R7", "output held with ce low", y_out, hy);
      check(sb.size() == 3, "R7", "nothing taken with ce low", sb.size(), 3);
      check(in_ready == 1'b0, "R7", "in_ready with ce low", in_ready, 0);
      @(negedge clk);
      ce = 1'b1;
    end
    cycles(LAT + 4);
    check(sb.size() == 0, "R8", "blocked results delivered", sb.size(), 0);

    // R7: freeze while an operand is in flight
    send(1'b0, 5000, 0, -5000);
    @(negedge clk);
    ce = 1'b0;
    begin
      bit moved;
      moved = 1'b0;
      repeat (10) begin
        @(negedge clk); #1;
        if (out_valid || in_ready) moved = 1'b1;
      end
      check(!moved, "R7", "pipeline frozen", moved, 0);
    end
    @(negedge clk);
    ce = 1'b1;
    cycles(LAT + 3);
    check(sb.size() == 0, "R7", "frozen result delivered after enable", sb.size(), 0);

    // R11 bubbles plus random flow control
    fc_random = 1'b1;
    for (int k = 0; k < 400; k++) begin
      logic v;
      v = logic'($urandom_range(0, 1));
      cur_tag = v ? "R4" : "R3";
      if ($urandom_range(0, 4) == 0) cycles(int'($urandom_range(1, 3)));
      rand_op(v);
    end
    fc_random = 1'b0;
    @(negedge clk);
    ce = 1'b1; out_ready = 1'b1;
    cycles(LAT + 10);
    #1;
    check(out_valid == 1'b0, "R11", "idle after drain", out_valid, 0);
    check(n_in == n_out, "R11", "results equal operands", n_out, n_in);
    check(sb.size() == 0, "R11", "scoreboard empty", sb.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule